// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer

This block runs the memory machine cycles of a small 8-bit processor bus and counts them in T-states. One T-state is one clock period. A caller raises a start request with a two-bit cycle kind and, for some kinds, an address. The sequencer then runs one of two cycles:

- an opcode fetch of four T-states;
- a memory read of three T-states.

During the cycle it drives the bus pins. The low address byte and the data share one multiplexed bus. The high address byte has its own lines. The strobes are an address latch enable, an active-low read, an active-low write and a memory/IO status line. The sequencer samples the read data on the bus and reports the end of each cycle with a one-clock done pulse.

An internal program counter supplies the address for sequential fetches and operand reads. An active-low reset input clears the counter to zero and raises a reset output for external devices. A bus hold request lets another master take the bus. The request is honoured only between machine cycles. The sequencer then stops driving the address and control lines and raises an acknowledge.

Tri-state pins are modelled as data outputs with separate drive enables. The low byte uses one enable. The address and control group uses another, which stays low while the bus is surrendered. A two-byte load-immediate instruction is run as a kind-3 fetch at the opcode address followed by a kind-1 read. The read then uses the next address, so the instruction takes seven T-states in total.

Top module: `mcyc_bus_seq`

## Requirements
- R1: While rst_in_n is sampled low at a clock edge, the block returns to idle with ale=0, rd_n=1, wr_n=1, hlda=0 and done=0, and the program counter becomes 0000h. An aborted cycle is abandoned. rst_out is 1 from the first edge that samples rst_in_n low until the first edge that samples it high.
- R2: An opcode fetch (kinds 0 and 3) occupies exactly 4 T-states. done is high for exactly the one clock after T4.
- R3: A memory read (kinds 1 and 2) occupies exactly 3 T-states. done is high for exactly the one clock after T3.
- R4: ale is 1 in T1 only. During T1, ad_oe=1, ad_o carries the low address byte and a_hi carries the high byte. ad_oe is 0 from T2 onward.
- R5: rd_n is 0 in T2 and T3 only, so it is 1 in T1, in T4 of a fetch and in the done clock. rdata takes ad_i at the clock edge that ends T3 and holds it at least through the done clock.
- R6: Kind encodings and program-counter effects:
  - Kind 0 fetches at the program counter, then increments it.
  - Kind 1 reads at the program counter, then increments it.
  - Kind 2 reads at addr_in and leaves the counter unchanged.
  - Kind 3 fetches at addr_in and sets the counter to addr_in+1.
- R7: A kind-3 cycle at 2000h followed by a kind-1 cycle reads the opcode from 2000h and the immediate byte from 2001h, for 7 T-states of bus activity in total.
- R8: hold is sampled only when no cycle is running. A cycle in progress completes, and hlda rises in the clock after the cycle's done clock. While hlda=1, bus_oe=0, ale=0 and rd_n=1.
- R9: hlda falls one clock after hold is sampled low. A start request made while the bus is held starts no cycle and leaves the program counter unchanged.
- R10: A start request made while a cycle is running is ignored: no further cycle follows and the program counter is unchanged.
- R11: wr_n stays 1 and io_m stays 0 (memory space) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_in_n | input | 1 | Synchronous active-low reset request |
| start | input | 1 | Request a machine cycle (taken when idle) |
| kind | input | 2 | Cycle kind, see R6 |
| addr_in | input | 16 | Explicit address for kinds 2 and 3 |
| hold | input | 1 | Bus hold request from another master |
| ad_i | input | 8 | Data read from the multiplexed bus |
| ad_o | output | 8 | Low address byte driven on the multiplexed bus |
| ad_oe | output | 1 | Drive enable for ad_o |
| a_hi | output | 8 | High address byte |
| bus_oe | output | 1 | Drive enable for address and control lines (0 = released) |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | Memory (0) / IO (1) status |
| rdata | output | 8 | Byte captured at the end of T3 |
| hlda | output | 1 | Hold acknowledge |
| done | output | 1 | One-clock pulse after each machine cycle |
| rst_out | output | 1 | Reset indication for external devices |

## Verification
Three kinds of internal fault show up at the ports, and each shows up quickly:
- A wrong T-state count moves the rd_n window or the done pulse by whole clocks. It is visible within the same machine cycle.
- A program counter that is wrong, or that was disturbed by an ignored start request, shows up at the next counter-based cycle as the wrong address on ad_o and a_hi during T1.
- A hold state that is entered at the wrong moment, or that is left late, moves the rise or fall of hlda and bus_oe by one clock. The bench compares these clock by clock.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_HELD = 2'd2
  } phase_t;

  localparam logic [1:0] K_FETCH_PC  = 2'd0;
  localparam logic [1:0] K_READ_PC   = 2'd1;
  localparam logic [1:0] K_READ_ABS  = 2'd2;
  localparam logic [1:0] K_FETCH_ABS = 2'd3;
endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int AW      = 16,
  parameter int FETCH_T = 4,
  parameter int READ_T  = 3,
  parameter int TW      = 3
) (
  input  logic          clk,
  input  logic          rst_in_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr_in,
  input  logic          hold,
  output phase_t        nxt_phase,
  output logic [TW-1:0] nxt_tcnt,
  output logic [AW-1:0] nxt_addr,
  output logic          sample_now,
  output logic          cycle_end
);
  localparam logic [TW-1:0] FETCH_LAST = TW'(FETCH_T);
  localparam logic [TW-1:0] READ_LAST  = TW'(READ_T);

  phase_t        phase_q;
  logic [TW-1:0] tcnt_q;
  logic          fetch_q, nxt_fetch;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] pc_q, nxt_pc;
  logic [TW-1:0] cur_last;

  assign cur_last   = fetch_q ? FETCH_LAST : READ_LAST;
  assign sample_now = (phase_q == PH_RUN) && (tcnt_q == READ_LAST);
  assign cycle_end  = (phase_q == PH_RUN) && (tcnt_q == cur_last);

  always_comb begin
    nxt_phase = phase_q;
    nxt_tcnt  = tcnt_q;
    nxt_fetch = fetch_q;
    nxt_addr  = addr_q;
    nxt_pc    = pc_q;
    case (phase_q)
      PH_IDLE: begin
        if (hold) begin
          nxt_phase = PH_HELD;
        end else if (start) begin
          nxt_phase = PH_RUN;
          nxt_tcnt  = TW'(1);
          case (kind)
            K_FETCH_PC: begin
              nxt_fetch = 1'b1;
              nxt_addr  = pc_q;
              nxt_pc    = pc_q + AW'(1);
            end
            K_READ_PC: begin
              nxt_fetch = 1'b0;
              nxt_addr  = pc_q;
              nxt_pc    = pc_q + AW'(1);
            end
            K_READ_ABS: begin
              nxt_fetch = 1'b0;
              nxt_addr  = addr_in;
            end
            default: begin
              nxt_fetch = 1'b1;
              nxt_addr  = addr_in;
              nxt_pc    = addr_in + AW'(1);
            end
          endcase
        end
      end
      PH_RUN: begin
        if (tcnt_q == cur_last) begin
          nxt_phase = PH_IDLE;
          nxt_tcnt  = '0;
        end else begin
          nxt_tcnt = tcnt_q + TW'(1);
        end
      end
      PH_HELD: begin
        if (!hold) nxt_phase = PH_IDLE;
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_in_n) begin
      phase_q <= PH_IDLE;
      tcnt_q  <= '0;
      fetch_q <= 1'b0;
      addr_q  <= '0;
      pc_q    <= '0;
    end else begin
      phase_q <= nxt_phase;
      tcnt_q  <= nxt_tcnt;
      fetch_q <= nxt_fetch;
      addr_q  <= nxt_addr;
      pc_q    <= nxt_pc;
    end
  end
endmodule

// File: rtl/mcyc_pins.sv
module mcyc_pins
  import mcyc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int READ_T = 3,
  parameter int TW     = 3
) (
  input  logic             clk,
  input  logic             rst_in_n,
  input  phase_t           nxt_phase,
  input  logic [TW-1:0]    nxt_tcnt,
  input  logic [AW-1:0]    nxt_addr,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             bus_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             hlda
);
  localparam logic [TW-1:0] RD_FIRST = TW'(2);
  localparam logic [TW-1:0] RD_LAST  = TW'(READ_T);

  logic run_n, t1_n, rd_win_n;

  assign run_n    = (nxt_phase == PH_RUN);
  assign t1_n     = run_n && (nxt_tcnt == TW'(1));
  assign rd_win_n = run_n && (nxt_tcnt >= RD_FIRST) && (nxt_tcnt <= RD_LAST);

  always_ff @(posedge clk) begin
    if (!rst_in_n) begin
      ad_o   <= '0;
      ad_oe  <= 1'b0;
      a_hi   <= '0;
      bus_oe <= 1'b1;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      hlda   <= 1'b0;
    end else begin
      ale    <= t1_n;
      ad_oe  <= t1_n;
      rd_n   <= !rd_win_n;
      hlda   <= (nxt_phase == PH_HELD);
      bus_oe <= (nxt_phase != PH_HELD);
      if (t1_n) begin
        ad_o <= nxt_addr[DW-1:0];
        a_hi <= nxt_addr[AW-1:DW];
      end
    end
  end
endmodule

// File: rtl/mcyc_capture.sv
module mcyc_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_in_n,
  input  logic          sample_now,
  input  logic          cycle_end,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (!rst_in_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= cycle_end;
      if (sample_now) rdata <= ad_i;
    end
  end
endmodule

// File: rtl/mcyc_bus_seq.sv
module mcyc_bus_seq
  import mcyc_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int FETCH_T = 4,
  parameter int READ_T  = 3
) (
  input  logic             clk,
  input  logic             rst_in_n,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [AW-1:0]    addr_in,
  input  logic             hold,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             bus_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic [DW-1:0]    rdata,
  output logic             hlda,
  output logic             done,
  output logic             rst_out
);
  localparam int TW = $clog2(FETCH_T + 1);

  phase_t        nxt_phase;
  logic [TW-1:0] nxt_tcnt;
  logic [AW-1:0] nxt_addr;
  logic          sample_now, cycle_end;

  mcyc_ctrl #(.AW(AW), .FETCH_T(FETCH_T), .READ_T(READ_T), .TW(TW)) u_ctrl (
    .clk(clk), .rst_in_n(rst_in_n), .start(start), .kind(kind),
    .addr_in(addr_in), .hold(hold), .nxt_phase(nxt_phase),
    .nxt_tcnt(nxt_tcnt), .nxt_addr(nxt_addr), .sample_now(sample_now),
    .cycle_end(cycle_end)
  );

  mcyc_pins #(.AW(AW), .DW(DW), .READ_T(READ_T), .TW(TW)) u_pins (
    .clk(clk), .rst_in_n(rst_in_n), .nxt_phase(nxt_phase),
    .nxt_tcnt(nxt_tcnt), .nxt_addr(nxt_addr), .ad_o(ad_o), .ad_oe(ad_oe),
    .a_hi(a_hi), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n), .hlda(hlda)
  );

  mcyc_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_in_n(rst_in_n), .sample_now(sample_now),
    .cycle_end(cycle_end), .ad_i(ad_i), .rdata(rdata), .done(done)
  );

  assign wr_n = 1'b1;
  assign io_m = 1'b0;

  always_ff @(posedge clk) begin
    rst_out <= !rst_in_n;
  end
endmodule

// File: rtl/mcyc_bus_seq_chk.sv
module mcyc_bus_seq_chk (
  input logic clk,
  input logic rst_in_n,
  input logic hold,
  input logic ale,
  input logic rd_n,
  input logic bus_oe,
  input logic hlda,
  input logic done,
  input logic rst_out
);
  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_in_n) ale |=> !ale); // R4
  AST_ALE_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_in_n) ale |-> rd_n); // R5
  AST_DONE_RD_HIGH: assert property (@(posedge clk) disable iff (!rst_in_n) done |-> rd_n); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_in_n) done |=> !done); // R2
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_in_n) hlda |-> (!bus_oe && rd_n && !ale)); // R8
  AST_HLDA_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_in_n) $rose(hlda) |-> $past(hold)); // R8
  AST_HLDA_RELEASE: assert property (@(posedge clk) disable iff (!rst_in_n) (hlda && !hold) |=> !hlda); // R9
  AST_RST_OUT: assert property (@(posedge clk) !rst_in_n |=> rst_out); // R1
endmodule

bind mcyc_bus_seq mcyc_bus_seq_chk u_chk (
  .clk(clk), .rst_in_n(rst_in_n), .hold(hold), .ale(ale), .rd_n(rd_n),
  .bus_oe(bus_oe), .hlda(hlda), .done(done), .rst_out(rst_out)
);

// File: tb/sim_mcyc_bus_seq.sv
module sim_mcyc_bus_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_in_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [15:0] addr_in = 16'h0;
  logic        hold = 1'b0;
  logic [7:0]  ad_i;
  logic [7:0]  ad_o, a_hi, rdata;
  logic        ad_oe, bus_oe, ale, rd_n, wr_n, io_m, hlda, done, rst_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] mem_addr = 16'h0;
  logic [15:0] exp_pc = 16'h0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    if (a == 16'h2000) return 8'h3E;
    if (a == 16'h2001) return 8'h32;
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign ad_i = mem_val(mem_addr);

  mcyc_bus_seq u0 (
    .clk(clk), .rst_in_n(rst_in_n), .start(start), .kind(kind),
    .addr_in(addr_in), .hold(hold), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .a_hi(a_hi), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .rdata(rdata), .hlda(hlda), .done(done), .rst_out(rst_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one cycle; returns its T-state count. poke_start/poke_hold disturb it in T2.
  task automatic do_cycle(input logic [1:0] k, input logic [15:0] a,
                          input logic [15:0] exp_a, input int exp_len,
                          input bit poke_start, input bit poke_hold,
                          output int len);
    int n;
    @(negedge clk);
    start = 1'b1; kind = k; addr_in = a;
    @(negedge clk);
    start = 1'b0;
    mem_addr = exp_a;
    chk(ale && ad_oe && bus_oe, "R4 T1 ale/ad_oe", {ale, ad_oe}, 3);
    chk({a_hi, ad_o} == exp_a, "R4 T1 address", {a_hi, ad_o}, exp_a);
    chk(rd_n, "R5 rd_n high in T1", rd_n, 1);
    n = 1;
    while (n < 12) begin
      @(negedge clk);
      if (done) break;
      n++;
      if (poke_start && n == 2) begin start = 1'b1; kind = 2'd2; addr_in = 16'hFFFF; end
      if (poke_start && n == 3) start = 1'b0;
      if (poke_hold && n == 2) hold = 1'b1;
      chk(!ale && !ad_oe, "R4 ale/ad_oe low after T1", {ale, ad_oe}, 0);
      chk(rd_n == !(n == 2 || n == 3), "R5 rd_n window", rd_n, !(n == 2 || n == 3));
      chk(wr_n && !io_m && !hlda, "R11/R8 wr_n io_m hlda in cycle", {wr_n, io_m, hlda}, 4);
    end
    len = n;
    chk(n == exp_len, (exp_len == 4) ? "R2 fetch length" : "R3 read length", n, exp_len);
    chk(rdata == mem_val(exp_a), "R5 captured data", rdata, mem_val(exp_a));
    chk(rd_n, "R5 rd_n high in done clock", rd_n, 1);
  endtask

  initial begin
    int len, len2;
    logic [15:0] a;
    repeat (3) @(negedge clk);
    chk(rst_out, "R1 rst_out in reset", rst_out, 1);
    chk(!ale && rd_n && wr_n && !hlda && !done, "R1 idle bus in reset",
        {ale, rd_n, wr_n, hlda, done}, 5'b01100);
    rst_in_n = 1'b1;
    @(negedge clk);
    chk(!rst_out, "R1 rst_out after release", rst_out, 0);

    // R6: counter-based kinds from PC=0
    do_cycle(2'd0, 16'h0, 16'h0000, 4, 0, 0, len);
    do_cycle(2'd1, 16'h0, 16'h0001, 3, 0, 0, len);
    do_cycle(2'd2, 16'h1234, 16'h1234, 3, 0, 0, len);
    do_cycle(2'd0, 16'h0, 16'h0002, 4, 0, 0, len); // R6 kind 2 kept PC
    exp_pc = 16'h0003;

    // sweep of explicit-address kinds
    for (int i = 0; i < 64; i++) begin
      a = 16'(i * 1021 + 7);
      if (i % 2 == 1) begin
        do_cycle(2'd3, a, a, 4, 0, 0, len);
        exp_pc = a + 16'd1;
      end else begin
        do_cycle(2'd2, a, a, 3, 0, 0, len);
      end
    end
    do_cycle(2'd1, 16'h0, exp_pc, 3, 0, 0, len); // R6 kind 1 after kind 3
    exp_pc = exp_pc + 16'd1;

    // R7 load-immediate pair
    do_cycle(2'd3, 16'h2000, 16'h2000, 4, 0, 0, len);
    chk(rdata == 8'h3E, "R7 opcode byte", rdata, 8'h3E);
    do_cycle(2'd1, 16'h0, 16'h2001, 3, 0, 0, len2);
    chk(rdata == 8'h32, "R7 immediate byte", rdata, 8'h32);
    chk(len + len2 == 7, "R7 total T-states", len + len2, 7);
    exp_pc = 16'h2002;

    // R10 start during a running cycle
    do_cycle(2'd0, 16'h0, exp_pc, 4, 1, 0, len);
    exp_pc = exp_pc + 16'd1;
    @(negedge clk);
    chk(!ale && !done, "R10 no cycle from ignored start", {ale, done}, 0);
    do_cycle(2'd0, 16'h0, exp_pc, 4, 0, 0, len);
    exp_pc = exp_pc + 16'd1;

    // R8 hold raised during a cycle
    do_cycle(2'd1, 16'h0, exp_pc, 3, 0, 1, len);
    exp_pc = exp_pc + 16'd1;
    chk(!hlda && bus_oe, "R8 no hlda before cycle end", {hlda, bus_oe}, 1);
    @(negedge clk);
    chk(hlda && !bus_oe && rd_n, "R8 hlda after boundary", {hlda, bus_oe, rd_n}, 5);
    // R9 start while held
    start = 1'b1; kind = 2'd3; addr_in = 16'hBEEF;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(hlda && !ale && !done, "R9 held, start ignored", {hlda, ale, done}, 4);
    end
    start = 1'b0;
    hold = 1'b0;
    @(negedge clk);
    chk(!hlda && bus_oe, "R9 hlda drops one clock after hold", {hlda, bus_oe}, 1);
    do_cycle(2'd0, 16'h0, exp_pc, 4, 0, 0, len); // R9 PC unchanged
    exp_pc = exp_pc + 16'd1;

    // R8 hold while idle
    hold = 1'b1;
    @(negedge clk);
    chk(hlda && !bus_oe, "R8 hlda from idle", {hlda, bus_oe}, 2);
    hold = 1'b0;
    @(negedge clk);
    chk(!hlda, "R9 release from idle", hlda, 0);

    // R1 reset in mid-cycle
    @(negedge clk);
    start = 1'b1; kind = 2'd3; addr_in = 16'h5555;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_in_n = 1'b0;
    @(negedge clk);
    chk(rst_out && rd_n && !ale, "R1 abort cycle", {rst_out, rd_n, ale}, 6);
    @(negedge clk);
    rst_in_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done, "R1 aborted cycle gives no done", done, 0);
    do_cycle(2'd0, 16'h0, 16'h0000, 4, 0, 0, len); // R1 PC back to 0

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule